// File: doc/BRIEF.md
# T1/J1 Alarm Signal Detector

This block sits behind a frame aligner on the receive side of a T1 or J1 line. The aligner supplies each received bit together with strobes that mark where the bit sits in the frame structure. The block watches that stream and reports three alarm signals, each as a flag that is refreshed at the end of every measurement window:

- a remote alarm indication, called Yellow;
- a loss-of-frame indication, called Red;
- an all-ones indication, called AIS.

Window lengths are counted in ticks of an external 1 ms strobe. The Yellow window and the Red window are 40 ms long. The AIS window is 60 ms long.

The Yellow rule depends on two configuration inputs, line flavour (T1 or J1) and framing (SF or ESF):

- **T1 SF:** the block counts ones in the second bit of every channel.
- **J1 SF:** the block counts zeros in the F-bit of the twelfth frame.
- **ESF:** the block builds 16-bit words from the data-link bits and votes over the recent words.

Red looks for any loss of sync. AIS needs sync lost for the whole window together with a low count of received zeros. The flags are raw, per-window presence indications. Longer declare and clear integration belongs to a later stage.

Top module: `alm_detector`

## Requirements
- R1: A synchronous active-high reset clears all counters, the data-link word, the vote history and the three output flags. The flags read 0 in the first cycle after reset.
- R2: The Yellow and Red flags change only on the clock edge that ends a window of 40 `tick_1ms` pulses, and AIS only at the end of 60 pulses. A flag keeps its value after 39 ticks. An event that arrives in the cycle of a closing tick is counted in the new window.
- R3: With `cfg_esf`=0 and `cfg_j1`=0, a ones event is a cycle with `bit_stb`=1, `fbit_stb`=0, `bit_idx`=1 (index 0 is the first bit of the channel) and `rx_bit`=1. Yellow is 1 when at most 16 such events fall in the window and 0 when 17 or more do.
- R4: With `cfg_esf`=0 and `cfg_j1`=1, a zeros event is a cycle with `fbit_stb`=1, `frame_idx`=11 (zero-based, so the twelfth frame) and `rx_bit`=0. Yellow is 1 when at most 2 such events fall in the window and 0 when 3 or more do.
- R5: With `cfg_esf`=1, each `dl_stb` cycle shifts `rx_bit` into a 16-bit word, first bit in the MSB. The word is compared only once its 16th bit arrives. The target word is 0xFF00 when `cfg_j1`=0 and 0xFFFF when `cfg_j1`=1. A partly built word has no effect on the vote.
- R6: With `cfg_esf`=1 and `cfg_vote5`=0, Yellow is 1 when at least 8 of the last 10 completed words matched.
- R7: With `cfg_esf`=1 and `cfg_vote5`=1, only the newest 5 completed words count, and Yellow is 1 when at least 4 of them matched.
- R8: Red is 1 when `in_sync` was 0 in at least one cycle of the 40 ms window, and 0 otherwise.
- R9: AIS is 1 when two conditions hold over the 60 ms window: `in_sync` was 0 in every cycle, and fewer than 127 cycles had `bit_stb`=1 with `rx_bit`=0. If `in_sync` is 1 in any cycle, or 127 or more zeros arrive, AIS is 0.
- R10: Strobes that do not belong to the selected Yellow mode are ignored. These are ones at other bit indices, F-bits of other frames, and bit-2 ones while in ESF. With `cfg_esf`=1 and no completed words, Yellow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_j1 | input | 1 | 1 selects J1 behaviour, 0 selects T1 |
| cfg_esf | input | 1 | 1 selects ESF framing, 0 selects SF |
| cfg_vote5 | input | 1 | 1 selects 4-of-5 voting, 0 selects 8-of-10 |
| in_sync | input | 1 | Framer in frame sync |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| rx_bit | input | 1 | Received data bit for the current strobe |
| bit_stb | input | 1 | `rx_bit` is a channel data bit |
| bit_idx | input | 3 | Bit position within the channel, 0 = first |
| fbit_stb | input | 1 | `rx_bit` is a framing bit |
| frame_idx | input | 4 | Zero-based frame number within the superframe |
| dl_stb | input | 1 | `rx_bit` is a data-link bit (ESF) |
| yellow_o | output | 1 | Yellow signal present in the last window |
| red_o | output | 1 | Red signal present in the last window |
| ais_o | output | 1 | AIS signal present in the last window |

## Verification
A wrong event count or a miscounted window shows at the ports only as a wrong flag. It appears one clock after the window closes, which is up to 40 or 60 ticks after the error. For this reason each check waits for the exact closing tick and samples just after it.

A wrong vote history persists across windows. It can stay hidden until the data-link sequence puts the match count right at the threshold. The tests therefore drive words that land exactly on 8 of 10 and on 4 of 5. They also drive one sequence that passes the 8-of-10 vote but fails the 4-of-5 vote.

// File: rtl/alm_pkg.sv
package alm_pkg;
  typedef enum logic [1:0] {
    YS_T1_SF = 2'd0,
    YS_J1_SF = 2'd1,
    YS_ESF   = 2'd2
  } yel_src_e;

  function automatic yel_src_e pick_src(input logic j1, input logic esf);
    if (esf)     return YS_ESF;
    else if (j1) return YS_J1_SF;
    else         return YS_T1_SF;
  endfunction

  function automatic logic [15:0] dl_target(input logic j1);
    return j1 ? 16'hFFFF : 16'hFF00;
  endfunction
endpackage

// File: rtl/alm_win_timer.sv
module alm_win_timer #(
  parameter int WIN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic last
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  logic [CW-1:0] cnt;

  assign last = tick && (cnt == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (last) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(cnt));
endmodule

// File: rtl/alm_evt_counter.sv
module alm_evt_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (restart)             cnt <= inc ? CW'(1) : '0;
    else if (inc && cnt != '1)    cnt <= cnt + 1'b1;
  end

  // R3
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(restart) |-> cnt >= $past(cnt));
endmodule

// File: rtl/alm_esf_vote.sv
module alm_esf_vote #(
  parameter int PAT_W   = 16,
  parameter int LONG_N  = 10,
  parameter int LONG_K  = 8,
  parameter int SHORT_N = 5,
  parameter int SHORT_K = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dl_stb,
  input  logic             dl_bit,
  input  logic [PAT_W-1:0] target,
  input  logic             vote5,
  output logic             vote_ok
);
  localparam int BW = $clog2(PAT_W);
  localparam int PW = $clog2(LONG_N + 1);

  logic [PAT_W-1:0]  word;
  logic [BW-1:0]     nbits;
  logic [LONG_N-1:0] hist;
  logic [PAT_W-1:0]  next_word;
  logic              word_done;
  logic [PW-1:0]     pop_long, pop_short;

  assign next_word = {word[PAT_W-2:0], dl_bit};
  assign word_done = dl_stb && (nbits == BW'(PAT_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      nbits <= '0;
      hist  <= '0;
    end else if (dl_stb) begin
      word <= next_word;
      if (word_done) begin
        nbits <= '0;
        hist  <= {hist[LONG_N-2:0], next_word == target};
      end else begin
        nbits <= nbits + 1'b1;
      end
    end
  end

  always_comb begin
    pop_long  = '0;
    pop_short = '0;
    for (int i = 0; i < LONG_N; i++) begin
      pop_long = pop_long + PW'(hist[i]);
      if (i < SHORT_N) pop_short = pop_short + PW'(hist[i]);
    end
  end

  assign vote_ok = vote5 ? (pop_short >= PW'(SHORT_K)) : (pop_long >= PW'(LONG_K));

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dl_stb) |-> $stable(hist));
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dl_stb) |-> $stable(word) && $stable(nbits));
endmodule

// File: rtl/alm_detector.sv
module alm_detector #(
  parameter int YEL_WIN_MS    = 40,
  parameter int AIS_WIN_MS    = 60,
  parameter int CNT_W         = 8,
  parameter int T1_ONES_MAX   = 16,
  parameter int J1_ZEROS_MAX  = 2,
  parameter int AIS_ZEROS_LIM = 127,
  parameter int IDX_W         = 3,
  parameter int FR_W          = 4,
  parameter int YEL_BIT_IDX   = 1,
  parameter int YEL_FRAME     = 11,
  parameter int PAT_W         = 16,
  parameter int LONG_N        = 10,
  parameter int LONG_K        = 8,
  parameter int SHORT_N       = 5,
  parameter int SHORT_K       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_j1,
  input  logic             cfg_esf,
  input  logic             cfg_vote5,
  input  logic             in_sync,
  input  logic             tick_1ms,
  input  logic             rx_bit,
  input  logic             bit_stb,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             fbit_stb,
  input  logic [FR_W-1:0]  frame_idx,
  input  logic             dl_stb,
  output logic             yellow_o,
  output logic             red_o,
  output logic             ais_o
);
  import alm_pkg::*;

  logic bnd_yel, bnd_ais;
  logic ones_ev, j1z_ev, aisz_ev;
  logic [CNT_W-1:0] ones_cnt, j1z_cnt, aisz_cnt;
  logic vote_ok;
  logic loss_seen, loss_all;
  logic yel_now;
  yel_src_e src;

  alm_win_timer #(.WIN(YEL_WIN_MS)) u_tmr_yel (
    .clk(clk), .rst(rst), .tick(tick_1ms), .last(bnd_yel));
  alm_win_timer #(.WIN(AIS_WIN_MS)) u_tmr_ais (
    .clk(clk), .rst(rst), .tick(tick_1ms), .last(bnd_ais));

  assign ones_ev = bit_stb && !fbit_stb && (bit_idx == IDX_W'(YEL_BIT_IDX)) && rx_bit;
  assign j1z_ev  = fbit_stb && (frame_idx == FR_W'(YEL_FRAME)) && !rx_bit;
  assign aisz_ev = bit_stb && !rx_bit;

  alm_evt_counter #(.CW(CNT_W)) u_cnt_ones (
    .clk(clk), .rst(rst), .restart(bnd_yel), .inc(ones_ev), .cnt(ones_cnt));
  alm_evt_counter #(.CW(CNT_W)) u_cnt_j1z (
    .clk(clk), .rst(rst), .restart(bnd_yel), .inc(j1z_ev), .cnt(j1z_cnt));
  alm_evt_counter #(.CW(CNT_W)) u_cnt_aisz (
    .clk(clk), .rst(rst), .restart(bnd_ais), .inc(aisz_ev), .cnt(aisz_cnt));

  alm_esf_vote #(
    .PAT_W(PAT_W), .LONG_N(LONG_N), .LONG_K(LONG_K),
    .SHORT_N(SHORT_N), .SHORT_K(SHORT_K)
  ) u_vote (
    .clk(clk), .rst(rst), .dl_stb(dl_stb), .dl_bit(rx_bit),
    .target(PAT_W'(dl_target(cfg_j1))), .vote5(cfg_vote5), .vote_ok(vote_ok));

  assign src = pick_src(cfg_j1, cfg_esf);

  always_comb begin
    case (src)
      YS_T1_SF: yel_now = ones_cnt <= CNT_W'(T1_ONES_MAX);
      YS_J1_SF: yel_now = j1z_cnt <= CNT_W'(J1_ZEROS_MAX);
      default:  yel_now = vote_ok;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loss_seen <= 1'b0;
      loss_all  <= 1'b1;
      yellow_o  <= 1'b0;
      red_o     <= 1'b0;
      ais_o     <= 1'b0;
    end else begin
      if (bnd_yel) begin
        yellow_o  <= yel_now;
        red_o     <= loss_seen;
        loss_seen <= !in_sync;
      end else begin
        loss_seen <= loss_seen || !in_sync;
      end
      if (bnd_ais) begin
        ais_o    <= loss_all && (aisz_cnt < CNT_W'(AIS_ZEROS_LIM));
        loss_all <= !in_sync;
      end else begin
        loss_all <= loss_all && !in_sync;
      end
    end
  end

  // R2
  yel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd_yel) |-> $stable(yellow_o));
  // R2
  red_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd_yel) |-> $stable(red_o));
  // R2
  ais_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd_ais) |-> $stable(ais_o));
  // R8
  red_loss_chk: assert property (@(posedge clk) disable iff (rst)
    bnd_yel && !in_sync |=> loss_seen);
  // R9
  ais_sync_chk: assert property (@(posedge clk) disable iff (rst)
    in_sync |=> !loss_all);
endmodule

// File: tb/alm_detector_test.sv
module alm_detector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_j1 = 0, cfg_esf = 0, cfg_vote5 = 0, in_sync = 1;
  logic tick_1ms = 0, rx_bit = 0, bit_stb = 0, fbit_stb = 0, dl_stb = 0;
  logic [2:0] bit_idx = '0;
  logic [3:0] frame_idx = '0;
  logic yellow_o, red_o, ais_o;

  int total = 0, bad = 0;
  int phase = 0, ticks = 0;

  always #5 clk = ~clk;

  alm_detector uut (
    .clk(clk), .rst(rst), .cfg_j1(cfg_j1), .cfg_esf(cfg_esf), .cfg_vote5(cfg_vote5),
    .in_sync(in_sync), .tick_1ms(tick_1ms), .rx_bit(rx_bit), .bit_stb(bit_stb),
    .bit_idx(bit_idx), .fbit_stb(fbit_stb), .frame_idx(frame_idx), .dl_stb(dl_stb),
    .yellow_o(yellow_o), .red_o(red_o), .ais_o(ais_o));

  // kind (0: T1 SF bit-2 ones, 1: J1 SF frame-12 zeros), event count, expected Yellow
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{0, 0, 1}, '{0, 16, 1}, '{0, 17, 0}, '{0, 40, 0},
    '{1, 0, 1}, '{1, 2, 1}, '{1, 3, 0}};

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic adv_idle();
    @(negedge clk);
    {bit_stb, fbit_stb, dl_stb, rx_bit} = '0;
    bit_idx = '0; frame_idx = '0;
    tick_1ms = (phase == 7);
    phase = (phase == 7) ? 0 : phase + 1;
    if (tick_1ms) ticks++;
  endtask

  task automatic step(input logic bv, input logic [2:0] idx, input logic fb,
                      input logic [3:0] fr, input logic dl, input logic rx);
    do adv_idle(); while (tick_1ms);
    bit_stb = bv; bit_idx = idx; fbit_stb = fb; frame_idx = fr; dl_stb = dl; rx_bit = rx;
  endtask

  task automatic wait_ticks(input int t);
    while (ticks < t) adv_idle();
    adv_idle();
  endtask

  task automatic do_reset(input logic j1, input logic esf, input logic v5, input logic sync);
    @(negedge clk);
    rst = 1; tick_1ms = 0;
    cfg_j1 = j1; cfg_esf = esf; cfg_vote5 = v5; in_sync = sync;
    repeat (3) @(negedge clk);
    rst = 0; phase = 0; ticks = 0;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) step(0, 3'd0, 0, 4'd0, 1, w[b]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: flags clear right after reset
    do_reset(0, 0, 0, 0);
    @(negedge clk);
    chk("R1 yellow", yellow_o, 0);
    chk("R1 red", red_o, 0);
    chk("R1 ais", ais_o, 0);

    // R2: no update before the 40th tick
    do_reset(0, 0, 0, 1);
    wait_ticks(39);
    chk("R2 yellow before window end", yellow_o, 0);
    wait_ticks(40);
    chk("R2 yellow at window end", yellow_o, 1);

    // R3 / R4 table, with R10 decoys
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][0] != 0, 0, 0, 1);
      for (int n = 0; n < VEC[v][1]; n++) begin
        if (VEC[v][0] == 0) step(1, 3'd1, 0, 4'd0, 0, 1);
        else                step(0, 3'd0, 1, 4'd11, 0, 0);
      end
      for (int n = 0; n < 20; n++) begin
        if (VEC[v][0] == 0) step(1, 3'd2, 0, 4'd0, 0, 1);
        else begin
          step(0, 3'd0, 1, 4'd3, 0, 0);
          step(0, 3'd0, 1, 4'd11, 0, 1);
        end
      end
      wait_ticks(40);
      chk(VEC[v][0] == 0 ? "R3 T1 SF yellow (R10 decoys)" : "R4 J1 SF yellow (R10 decoys)",
          yellow_o, VEC[v][2] != 0);
    end

    // R10: ESF ignores bit-2 activity, no words -> no Yellow
    do_reset(0, 1, 0, 1);
    wait_ticks(40);
    chk("R10 ESF without words", yellow_o, 0);

    // R6: exactly 8 of 10 match
    do_reset(0, 1, 0, 1);
    send_word(16'h0000); send_word(16'h1234);
    for (int k = 0; k < 8; k++) send_word(16'hFF00);
    wait_ticks(40);
    chk("R6 8 of 10", yellow_o, 1);

    // R6: 7 of 10 match
    do_reset(0, 1, 0, 1);
    for (int k = 0; k < 3; k++) send_word(16'h0000);
    for (int k = 0; k < 7; k++) send_word(16'hFF00);
    wait_ticks(40);
    chk("R6 7 of 10", yellow_o, 0);

    // R7: n m m m m -> 4 of 5
    do_reset(0, 1, 1, 1);
    send_word(16'h0000);
    for (int k = 0; k < 4; k++) send_word(16'hFF00);
    wait_ticks(40);
    chk("R7 4 of 5", yellow_o, 1);

    // R7 vs R6: m*7 n n m -> 3 of newest 5, 8 of 10
    for (int mode = 1; mode >= 0; mode--) begin
      do_reset(0, 1, mode != 0, 1);
      for (int k = 0; k < 7; k++) send_word(16'hFF00);
      send_word(16'h0000); send_word(16'h0000); send_word(16'hFF00);
      wait_ticks(40);
      if (mode != 0) chk("R7 only newest 5 count", yellow_o, 0);
      else           chk("R6 same sequence passes 8 of 10", yellow_o, 1);
    end

    // R5: J1 target is FFFF, FF00 does not match
    do_reset(1, 1, 0, 1);
    for (int k = 0; k < 10; k++) send_word(16'hFF00);
    wait_ticks(40);
    chk("R5 J1 rejects FF00", yellow_o, 0);
    do_reset(1, 1, 0, 1);
    for (int k = 0; k < 10; k++) send_word(16'hFFFF);
    wait_ticks(40);
    chk("R5 J1 accepts FFFF", yellow_o, 1);

    // R5: partial word not compared until the 16th bit
    do_reset(1, 1, 1, 1);
    for (int k = 0; k < 3; k++) send_word(16'hFFFF);
    for (int b = 0; b < 15; b++) step(0, 3'd0, 0, 4'd0, 1, 1);
    wait_ticks(40);
    chk("R5 partial word ignored", yellow_o, 0);
    step(0, 3'd0, 0, 4'd0, 1, 1);
    wait_ticks(80);
    chk("R5 word completes", yellow_o, 1);

    // R8: red
    do_reset(0, 0, 0, 1);
    wait_ticks(40);
    chk("R8 red with sync held", red_o, 0);
    step(0, 3'd0, 0, 4'd0, 0, 0);
    in_sync = 0;
    step(0, 3'd0, 0, 4'd0, 0, 0);
    in_sync = 1;
    wait_ticks(80);
    chk("R8 red after one lost cycle", red_o, 1);
    wait_ticks(120);
    chk("R8 red clears in clean window", red_o, 0);

    // R9: AIS
    do_reset(0, 0, 0, 0);
    for (int n = 0; n < 126; n++) step(1, 3'd0, 0, 4'd0, 0, 0);
    wait_ticks(40);
    chk("R8 red while out of sync", red_o, 1);
    chk("R9 ais not before 60 ticks", ais_o, 0);
    wait_ticks(60);
    chk("R9 ais with 126 zeros", ais_o, 1);

    do_reset(0, 0, 0, 0);
    for (int n = 0; n < 127; n++) step(1, 3'd0, 0, 4'd0, 0, 0);
    wait_ticks(60);
    chk("R9 ais with 127 zeros", ais_o, 0);

    do_reset(0, 0, 0, 0);
    step(0, 3'd0, 0, 4'd0, 0, 0);
    in_sync = 1;
    step(0, 3'd0, 0, 4'd0, 0, 0);
    in_sync = 0;
    wait_ticks(60);
    chk("R9 ais blocked by brief sync", ais_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule